// File: doc/BRIEF.md
# Register Block with Broadcast Aliases

This block is a memory-mapped control register file behind a simple request/response port. Each register holds one 8-bit field, readable at bits 7:0 of a 32-bit word, that resets to zero and is driven to a hardware output slice. The block also decodes a set of broadcast alias addresses. An alias has no storage and no output of its own. A write to an alias loads the written byte into every register mapped to it, all in the same cycle. A read from an alias returns the bitwise OR of the mapped registers that can be read.

Group aliases mirror a whole register group. Each offset inside the alias group maps to the register at the same offset in every target group. The register addresses, the alias addresses with their target masks, and the per-register access kind are all elaboration-time parameters. The defaults are built by package functions.

Each register has one of three access kinds. A read-write register is stored. A write-only register is stored but always reads as zero. A read-only register mirrors its hardware status input slice and ignores writes. Every request is answered by a one-cycle response on the next clock.

Top module: `bcast_regblock`

## Requirements
- R1: A synchronous active-high reset clears every stored field to zero and holds rspValid and rspErr low. Stored fields belong to read-write and write-only registers; their output slices read zero after reset.
- R2: A write to a register's own address loads reqWdata[7:0] into that register only. The new value is visible on hwFieldOut[8*i+7:8*i] and in readback from the cycle after the request. Every other register keeps its value.
- R3: A write to an alias loads reqWdata[7:0] into every writable register in the alias mask at the same clock edge. Registers outside the mask are unchanged. In the default map, alias 0x0C0 targets registers 0, 1 and 2 at 0x000, 0x004 and 0x008, and alias 0x214 targets the write-only register 16.
- R4: In the default map, the five groups of three registers sit at bases 0x000, 0x010, 0x020, 0x100 and 0x110, with offsets 0, 4 and 8, and register index = 3*group + offset/4. Group alias base 0x040 mirrors groups 0, 1 and 2. Group alias base 0x080 mirrors groups 3 and 4. A write to base+offset touches only the register at that offset in each target group.
- R5: A read of a register address returns {24'b0, field} with rdata[31:8] always zero. Register 15 at 0x200 is read-only, and it reads its hwStatusIn[127:120] slice, which it also drives on its hwFieldOut slice.
- R6: A read of an alias returns the bitwise OR of the fields of its readable targets. Write-only targets contribute zero to this OR.
- R7: Every cycle with reqValid high yields exactly one cycle of rspValid high on the next cycle. rspValid is low in the cycle after a cycle without a request.
- R8: With ERR_ON_BAD = 1, an address that matches no register and no alias (for example 0x300) returns rspErr = 1 and rdata 0, for both reads and writes.
- R9: With ERR_ON_BAD = 1, a write whose decoded targets include no writable register returns rspErr = 1 and changes nothing. This covers the alias at 0x210 and a direct write to 0x200. A read whose decoded targets include no readable register returns rspErr = 1 with rdata 0. This covers the alias at 0x214 and a direct read of 0x204.
- R10: A write that reaches at least one writable target returns rspErr = 0, and every write response carries rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request valid for this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWdata | input | 32 | Write data; bits 7:0 are stored |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspRdata | output | 32 | Read data (zero for writes and errors) |
| rspErr | output | 1 | Bad-access error flag |
| hwStatusIn | input | 8*NUM_REGS | Status slices read by read-only registers |
| hwFieldOut | output | 8*NUM_REGS | Field value of each register |

## Verification
The bound checker watches every cycle for several properties. It checks the one-cycle response pulse, zero upper read data, zero data on errors and on write responses, and the clearing of stored fields by reset. It checks that stored fields hold still when no write is requested. It checks that an alias write lands in every writable target on the next edge, and that unmapped addresses are flagged. The bench scenarios are needed for the values that depend on history: the OR-combined alias reads after mixed direct and broadcast writes, per-offset group mirroring leaving the other offsets untouched, read-only registers ignoring writes, and write-only registers reading as zero.

// File: rtl/bcast_regblock_pkg.sv
package bcast_regblock_pkg;

  localparam int DATA_W        = 32;
  localparam int FIELD_W       = 8;
  localparam int DEF_ADDR_W    = 12;
  localparam int DEF_NUM_REGS  = 17;
  localparam int DEF_NUM_ALIAS = 9;
  localparam int GROUP_LEN     = 3;
  localparam int NUM_GROUPS    = 5;

  // access kind per register, 2 bits each
  localparam logic [1:0] ACC_RW = 2'd0;
  localparam logic [1:0] ACC_RO = 2'd1;
  localparam logic [1:0] ACC_WO = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic active;
    logic isWrite;
    logic bad;
  } strobe_t;

  function automatic logic [DEF_ADDR_W-1:0] groupBase(input int g);
    case (g)
      0:       return 12'h000;
      1:       return 12'h010;
      2:       return 12'h020;
      3:       return 12'h100;
      default: return 12'h110;
    endcase
  endfunction

  function automatic logic [DEF_NUM_REGS*DEF_ADDR_W-1:0] defRegAddrs();
    logic [DEF_NUM_REGS*DEF_ADDR_W-1:0] v;
    v = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int k = 0; k < GROUP_LEN; k++) begin
        v[(g*GROUP_LEN+k)*DEF_ADDR_W +: DEF_ADDR_W] = groupBase(g) + DEF_ADDR_W'(4*k);
      end
    end
    v[15*DEF_ADDR_W +: DEF_ADDR_W] = 12'h200;
    v[16*DEF_ADDR_W +: DEF_ADDR_W] = 12'h204;
    return v;
  endfunction

  function automatic logic [DEF_NUM_ALIAS*DEF_ADDR_W-1:0] defAliasAddrs();
    logic [DEF_NUM_ALIAS*DEF_ADDR_W-1:0] v;
    v = '0;
    v[0 +: DEF_ADDR_W] = 12'h0C0;
    for (int k = 0; k < GROUP_LEN; k++) begin
      v[(1+k)*DEF_ADDR_W +: DEF_ADDR_W] = 12'h040 + DEF_ADDR_W'(4*k);
      v[(4+k)*DEF_ADDR_W +: DEF_ADDR_W] = 12'h080 + DEF_ADDR_W'(4*k);
    end
    v[7*DEF_ADDR_W +: DEF_ADDR_W] = 12'h210;
    v[8*DEF_ADDR_W +: DEF_ADDR_W] = 12'h214;
    return v;
  endfunction

  // one mask of DEF_NUM_REGS bits per alias; group aliases are expanded per offset
  function automatic logic [DEF_NUM_ALIAS*DEF_NUM_REGS-1:0] defAliasMasks();
    logic [DEF_NUM_ALIAS*DEF_NUM_REGS-1:0] m;
    m = '0;
    for (int k = 0; k < GROUP_LEN; k++) begin
      m[0*DEF_NUM_REGS + k] = 1'b1;
      for (int g = 0; g < 3; g++) m[(1+k)*DEF_NUM_REGS + g*GROUP_LEN + k] = 1'b1;
      for (int g = 3; g < 5; g++) m[(4+k)*DEF_NUM_REGS + g*GROUP_LEN + k] = 1'b1;
    end
    m[7*DEF_NUM_REGS + 15] = 1'b1;
    m[8*DEF_NUM_REGS + 16] = 1'b1;
    return m;
  endfunction

  function automatic logic [DEF_NUM_REGS*2-1:0] defAccess();
    logic [DEF_NUM_REGS*2-1:0] a;
    a = '0;
    a[15*2 +: 2] = ACC_RO;
    a[16*2 +: 2] = ACC_WO;
    return a;
  endfunction

endpackage

// File: rtl/bcast_regblock_ctrl.sv
module bcast_regblock_ctrl
  import bcast_regblock_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int NUM_REGS  = DEF_NUM_REGS,
  parameter int NUM_ALIAS = DEF_NUM_ALIAS,
  parameter logic [NUM_REGS*ADDR_W-1:0]    REG_ADDRS   = defRegAddrs(),
  parameter logic [NUM_ALIAS*ADDR_W-1:0]   ALIAS_ADDRS = defAliasAddrs(),
  parameter logic [NUM_ALIAS*NUM_REGS-1:0] ALIAS_MASKS = defAliasMasks(),
  parameter logic [NUM_REGS*2-1:0]         ACCESS      = defAccess(),
  parameter bit ERR_ON_BAD = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic [NUM_REGS-1:0] wrStb,
  output logic [NUM_REGS-1:0] rdSel,
  output strobe_t             stb,
  output logic                rspValid,
  output logic                rspErr
);

  function automatic logic [NUM_REGS-1:0] allowMask(input logic [1:0] denied);
    logic [NUM_REGS-1:0] m;
    for (int i = 0; i < NUM_REGS; i++) m[i] = (ACCESS[i*2 +: 2] != denied);
    return m;
  endfunction

  localparam logic [NUM_REGS-1:0] CAN_WR = allowMask(ACC_RO);
  localparam logic [NUM_REGS-1:0] CAN_RD = allowMask(ACC_WO);

  logic [NUM_ALIAS-1:0] aliasHit;
  logic [NUM_REGS-1:0]  regHit;
  logic                 anyWritable;
  logic                 anyReadable;

  for (genvar j = 0; j < NUM_ALIAS; j++) begin : g_alias
    assign aliasHit[j] = (reqAddr == ALIAS_ADDRS[j*ADDR_W +: ADDR_W]);
  end

  // a register is selected by its own address or by any alias that maps it
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [NUM_ALIAS-1:0] viaAlias;
    for (genvar j = 0; j < NUM_ALIAS; j++) begin : g_col
      assign viaAlias[j] = aliasHit[j] & ALIAS_MASKS[j*NUM_REGS + i];
    end
    assign regHit[i] = (reqAddr == REG_ADDRS[i*ADDR_W +: ADDR_W]) | (|viaAlias);
  end

  assign anyWritable = |(regHit & CAN_WR);
  assign anyReadable = |(regHit & CAN_RD);

  assign wrStb = {NUM_REGS{reqValid &  reqWrite}} & regHit & CAN_WR;
  assign rdSel = {NUM_REGS{reqValid & ~reqWrite}} & regHit & CAN_RD;

  always_comb begin
    stb.active  = reqValid;
    stb.isWrite = reqWrite;
    stb.bad     = ERR_ON_BAD && reqValid && (reqWrite ? !anyWritable : !anyReadable);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= stb.bad;
    end
  end

endmodule

// File: rtl/bcast_regblock_data.sv
module bcast_regblock_data
  import bcast_regblock_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter logic [NUM_REGS*2-1:0] ACCESS = defAccess()
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobe_t                     stb,
  input  logic [NUM_REGS-1:0]         wrStb,
  input  logic [NUM_REGS-1:0]         rdSel,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NUM_REGS*FIELD_W-1:0] hwStatusIn,
  output logic [NUM_REGS*FIELD_W-1:0] hwFieldOut,
  output logic [DATA_W-1:0]           rspRdata
);

  logic [NUM_REGS*FIELD_W-1:0] readVal;
  logic [NUM_REGS-1:0]         unusedBits;
  logic [FIELD_W-1:0]          orVal;
  logic                        unusedWdata;

  assign unusedWdata = ^wdata[DATA_W-1:FIELD_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_field
    if (ACCESS[i*2 +: 2] == ACC_RO) begin : g_ro
      assign hwFieldOut[i*FIELD_W +: FIELD_W] = hwStatusIn[i*FIELD_W +: FIELD_W];
      assign readVal[i*FIELD_W +: FIELD_W]    = hwStatusIn[i*FIELD_W +: FIELD_W];
      assign unusedBits[i] = wrStb[i];
    end else begin : g_stored
      logic [FIELD_W-1:0] fieldQ;
      always_ff @(posedge clk) begin
        if (rst)            fieldQ <= '0;
        else if (wrStb[i])  fieldQ <= wdata[FIELD_W-1:0];
      end
      assign hwFieldOut[i*FIELD_W +: FIELD_W] = fieldQ;
      if (ACCESS[i*2 +: 2] == ACC_WO) begin : g_wo
        assign readVal[i*FIELD_W +: FIELD_W] = '0;
        assign unusedBits[i] = rdSel[i] ^ (^hwStatusIn[i*FIELD_W +: FIELD_W]);
      end else begin : g_rw
        assign readVal[i*FIELD_W +: FIELD_W] = fieldQ;
        assign unusedBits[i] = ^hwStatusIn[i*FIELD_W +: FIELD_W];
      end
    end
  end

  // alias reads combine every selected target
  always_comb begin
    orVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdSel[i]) orVal = orVal | readVal[i*FIELD_W +: FIELD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspRdata <= '0;
    end else if (stb.active && !stb.isWrite && !stb.bad) begin
      rspRdata <= {{(DATA_W-FIELD_W){1'b0}}, orVal};
    end else begin
      rspRdata <= '0;
    end
  end

endmodule

// File: rtl/bcast_regblock.sv
module bcast_regblock
  import bcast_regblock_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int NUM_REGS  = DEF_NUM_REGS,
  parameter int NUM_ALIAS = DEF_NUM_ALIAS,
  parameter logic [NUM_REGS*ADDR_W-1:0]    REG_ADDRS   = defRegAddrs(),
  parameter logic [NUM_ALIAS*ADDR_W-1:0]   ALIAS_ADDRS = defAliasAddrs(),
  parameter logic [NUM_ALIAS*NUM_REGS-1:0] ALIAS_MASKS = defAliasMasks(),
  parameter logic [NUM_REGS*2-1:0]         ACCESS      = defAccess(),
  parameter bit ERR_ON_BAD = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  output logic                        rspValid,
  output logic [DATA_W-1:0]           rspRdata,
  output logic                        rspErr,
  input  logic [NUM_REGS*FIELD_W-1:0] hwStatusIn,
  output logic [NUM_REGS*FIELD_W-1:0] hwFieldOut
);

  strobe_t             stb;
  logic [NUM_REGS-1:0] wrStb;
  logic [NUM_REGS-1:0] rdSel;

  bcast_regblock_ctrl #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .NUM_ALIAS(NUM_ALIAS),
    .REG_ADDRS(REG_ADDRS), .ALIAS_ADDRS(ALIAS_ADDRS), .ALIAS_MASKS(ALIAS_MASKS),
    .ACCESS(ACCESS), .ERR_ON_BAD(ERR_ON_BAD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .wrStb(wrStb), .rdSel(rdSel), .stb(stb), .rspValid(rspValid), .rspErr(rspErr)
  );

  bcast_regblock_data #(
    .NUM_REGS(NUM_REGS), .ACCESS(ACCESS)
  ) u_data (
    .clk(clk), .rst(rst), .stb(stb), .wrStb(wrStb), .rdSel(rdSel), .wdata(reqWdata),
    .hwStatusIn(hwStatusIn), .hwFieldOut(hwFieldOut), .rspRdata(rspRdata)
  );

endmodule

// File: rtl/bcast_regblock_chk.sv
module bcast_regblock_chk
  import bcast_regblock_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int NUM_REGS  = DEF_NUM_REGS,
  parameter int NUM_ALIAS = DEF_NUM_ALIAS,
  parameter logic [NUM_REGS*ADDR_W-1:0]    REG_ADDRS   = defRegAddrs(),
  parameter logic [NUM_ALIAS*ADDR_W-1:0]   ALIAS_ADDRS = defAliasAddrs(),
  parameter logic [NUM_ALIAS*NUM_REGS-1:0] ALIAS_MASKS = defAliasMasks(),
  parameter logic [NUM_REGS*2-1:0]         ACCESS      = defAccess(),
  parameter bit ERR_ON_BAD = 1'b1
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        reqValid,
  input logic                        reqWrite,
  input logic [ADDR_W-1:0]           reqAddr,
  input logic [DATA_W-1:0]           reqWdata,
  input logic                        rspValid,
  input logic [DATA_W-1:0]           rspRdata,
  input logic                        rspErr,
  input logic [NUM_REGS*FIELD_W-1:0] hwStatusIn,
  input logic [NUM_REGS*FIELD_W-1:0] hwFieldOut
);

  function automatic logic [NUM_REGS*FIELD_W-1:0] storedMask();
    logic [NUM_REGS*FIELD_W-1:0] m;
    for (int i = 0; i < NUM_REGS; i++)
      m[i*FIELD_W +: FIELD_W] = (ACCESS[i*2 +: 2] == ACC_RO) ? '0 : '1;
    return m;
  endfunction

  localparam logic [NUM_REGS*FIELD_W-1:0] STORED = storedMask();

  logic [NUM_REGS*FIELD_W-1:0] storedView;
  logic                        mapped;
  logic                        unusedStatus;

  assign storedView   = hwFieldOut & STORED;
  assign unusedStatus = ^hwStatusIn;

  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if (reqAddr == REG_ADDRS[i*ADDR_W +: ADDR_W]) mapped = 1'b1;
    for (int j = 0; j < NUM_ALIAS; j++)
      if (reqAddr == ALIAS_ADDRS[j*ADDR_W +: ADDR_W]) mapped = 1'b1;
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rspValid && !rspErr && storedView == '0));

  // R2
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    !(reqValid && reqWrite) |=> $stable(storedView));

  // R5
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspRdata[DATA_W-1:FIELD_W] == '0));

  // R7
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  // R7
  p_rsp_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  // R8
  p_unmapped_err_r8: assert property (@(posedge clk) disable iff (rst)
    (ERR_ON_BAD && reqValid && !mapped) |=> (rspErr && rspRdata == '0));

  // R9
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspErr) |-> (rspRdata == '0));

  // R10
  p_wr_rsp_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite) |=> (rspRdata == '0));

  // R3: each writable target of an alias takes the written byte on the next edge
  for (genvar j = 0; j < NUM_ALIAS; j++) begin : g_fan
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_tgt
      if (ALIAS_MASKS[j*NUM_REGS + i] && ACCESS[i*2 +: 2] != ACC_RO) begin : g_on
        p_fanout_r3: assert property (@(posedge clk) disable iff (rst)
          (reqValid && reqWrite && reqAddr == ALIAS_ADDRS[j*ADDR_W +: ADDR_W])
          |=> (hwFieldOut[i*FIELD_W +: FIELD_W] == $past(reqWdata[FIELD_W-1:0])));
      end
    end
  end

endmodule

bind bcast_regblock bcast_regblock_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .NUM_ALIAS(NUM_ALIAS),
  .REG_ADDRS(REG_ADDRS), .ALIAS_ADDRS(ALIAS_ADDRS), .ALIAS_MASKS(ALIAS_MASKS),
  .ACCESS(ACCESS), .ERR_ON_BAD(ERR_ON_BAD)
) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
  .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
  .hwStatusIn(hwStatusIn), .hwFieldOut(hwFieldOut)
);

// File: tb/bcast_regblock_test.sv
`timescale 1ns/1ps
module bcast_regblock_test;

  localparam int NR = 17;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic          rspValid;
  logic [31:0]   rspRdata;
  logic          rspErr;
  logic [NR*8-1:0] hwStatusIn = '0;
  logic [NR*8-1:0] hwFieldOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  bcast_regblock uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
    .hwStatusIn(hwStatusIn), .hwFieldOut(hwFieldOut)
  );

  typedef struct packed {
    logic          wr;
    logic [11:0]   addr;
    logic [31:0]   wdata;
    logic [7:0]    expData;
    logic          expErr;
    logic [3:0]    tag;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h0C0, 32'hAABBCCDD, 8'h00, 1'b0, 4'd3},  // R3 alias write
    '{1'b0, 12'h000, 32'h0, 8'hDD, 1'b0, 4'd3},
    '{1'b0, 12'h004, 32'h0, 8'hDD, 1'b0, 4'd3},
    '{1'b0, 12'h008, 32'h0, 8'hDD, 1'b0, 4'd3},
    '{1'b0, 12'h010, 32'h0, 8'h00, 1'b0, 4'd3},           // R3 not mapped, untouched
    '{1'b1, 12'h004, 32'h00000011, 8'h00, 1'b0, 4'd2},  // R2 direct write
    '{1'b0, 12'h004, 32'h0, 8'h11, 1'b0, 4'd2},
    '{1'b0, 12'h000, 32'h0, 8'hDD, 1'b0, 4'd2},
    '{1'b1, 12'h008, 32'h00000022, 8'h00, 1'b0, 4'd2},
    '{1'b0, 12'h0C0, 32'h0, 8'hFF, 1'b0, 4'd6},           // R6 DD|11|22
    '{1'b1, 12'h044, 32'h12345678, 8'h00, 1'b0, 4'd4},  // R4 group offset 4
    '{1'b0, 12'h004, 32'h0, 8'h78, 1'b0, 4'd4},
    '{1'b0, 12'h014, 32'h0, 8'h78, 1'b0, 4'd4},
    '{1'b0, 12'h024, 32'h0, 8'h78, 1'b0, 4'd4},
    '{1'b0, 12'h010, 32'h0, 8'h00, 1'b0, 4'd4},
    '{1'b0, 12'h000, 32'h0, 8'hDD, 1'b0, 4'd4},
    '{1'b1, 12'h080, 32'hCAFEBABE, 8'h00, 1'b0, 4'd4},  // R4 second group alias
    '{1'b0, 12'h100, 32'h0, 8'hBE, 1'b0, 4'd4},
    '{1'b0, 12'h110, 32'h0, 8'hBE, 1'b0, 4'd4},
    '{1'b0, 12'h104, 32'h0, 8'h00, 1'b0, 4'd4},
    '{1'b0, 12'h040, 32'h0, 8'hDD, 1'b0, 4'd6},           // R6 group alias read
    '{1'b0, 12'h044, 32'h0, 8'h78, 1'b0, 4'd6},
    '{1'b0, 12'h300, 32'h0, 8'h00, 1'b1, 4'd8},           // R8 unmapped read
    '{1'b1, 12'h300, 32'h00000055, 8'h00, 1'b1, 4'd8},  // R8 unmapped write
    '{1'b1, 12'h210, 32'h00000099, 8'h00, 1'b1, 4'd9},  // R9 alias to read-only
    '{1'b0, 12'h210, 32'h0, 8'h3C, 1'b0, 4'd6},
    '{1'b0, 12'h200, 32'h0, 8'h3C, 1'b0, 4'd5},           // R5 read-only status
    '{1'b1, 12'h214, 32'h0000005A, 8'h00, 1'b0, 4'd10}, // R10 write-only alias write
    '{1'b0, 12'h214, 32'h0, 8'h00, 1'b1, 4'd9},           // R9 alias to write-only
    '{1'b0, 12'h204, 32'h0, 8'h00, 1'b1, 4'd9},
    '{1'b1, 12'h200, 32'h00000077, 8'h00, 1'b1, 4'd9},
    '{1'b0, 12'h200, 32'h0, 8'h3C, 1'b0, 4'd9},           // R9 write ignored
    '{1'b0, 12'h100, 32'h0, 8'hBE, 1'b0, 4'd2}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                       output logic v, output logic [31:0] rd, output logic e);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    v = rspValid; rd = rspRdata; e = rspErr;
  endtask

  function automatic logic [7:0] fieldOf(input int i);
    return hwFieldOut[i*8 +: 8];
  endfunction

  initial begin
    logic v, e;
    logic [31:0] rd;
    string tagName;

    repeat (3) @(negedge clk);
    check(rspValid == 1'b0, "R1 rspValid in reset", {31'b0, rspValid}, 32'h0);
    check(hwFieldOut == '0, "R1 fields in reset", hwFieldOut[31:0], 32'h0);
    rst = 1'b0;
    hwStatusIn[15*8 +: 8] = 8'h3C;
    @(negedge clk);
    check(fieldOf(15) == 8'h3C, "R5 read-only output", {24'b0, fieldOf(15)}, 32'h3C);
    check(rspValid == 1'b0, "R7 idle after reset", {31'b0, rspValid}, 32'h0);

    for (int n = 0; n < NV; n++) begin
      doReq(VEC[n].wr, VEC[n].addr, VEC[n].wdata, v, rd, e);
      tagName = $sformatf("R%0d vec%0d", VEC[n].tag, n);
      check(v == 1'b1, {tagName, " valid (R7)"}, {31'b0, v}, 32'h1);
      check(rd == {24'b0, VEC[n].expData}, {tagName, " data"}, rd, {24'b0, VEC[n].expData});
      check(e == VEC[n].expErr, {tagName, " err"}, {31'b0, e}, {31'b0, VEC[n].expErr});
    end

    // directed: hardware outputs after the sequence
    check(fieldOf(1) == 8'h78 && fieldOf(4) == 8'h78 && fieldOf(7) == 8'h78,
          "R4 group targets out", {8'b0, fieldOf(1), fieldOf(4), fieldOf(7)}, 32'h787878);
    check(fieldOf(10) == 8'h00, "R4 other offset out", {24'b0, fieldOf(10)}, 32'h0);
    check(fieldOf(16) == 8'h5A, "R3 write-only target out", {24'b0, fieldOf(16)}, 32'h5A);
    check(fieldOf(2) == 8'h22, "R2 direct write out", {24'b0, fieldOf(2)}, 32'h22);
    @(negedge clk);
    check(rspValid == 1'b0, "R7 single cycle", {31'b0, rspValid}, 32'h0);

    // mid-run reset
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check((hwFieldOut & ~({8'hFF} << (15*8))) == '0, "R1 mid-run clear",
          hwFieldOut[31:0], 32'h0);
    doReq(1'b0, 12'h0C0, 32'h0, v, rd, e);
    check(rd == 32'h0 && !e, "R1 alias read after reset", rd, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule